// File: doc/BRIEF.md
# DAC Output Update Controller

This block sits between a configuration register file and a two-channel digital-to-analog converter interface, all on one 100 MHz clock. Each cycle it packs two 16-bit channel codes into a registered 32-bit conversion word. It also registers a data-enable bit alongside that word. When the system reports a fault, the word is either frozen at its last value or forced to zero. A mode bit chooses which.

The block also produces a two-line, active-low load strobe for the converter. A rising edge on the start-up request starts a down-counter, which is 5 bits wide by default. While that counter is non-zero, the lines named by a 2-bit selection field are pulled low. A request edge that arrives while a pulse is running is dropped. A new pulse needs a fresh rising edge after the counter has returned to zero.

Top module: `dac_update_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the outputs after that edge are `dac_word` = 0, `dac_word_en` = 0 and `load_strobe_n` = 2'b11.
- R2: With `sys_fault` low, `dac_word` shows `{ch1_code, ch0_code}` one clock after the codes are sampled. Channel 1 occupies bits 31:16 and channel 0 occupies bits 15:0.
- R3: `dac_word_en` equals the value of `data_en_in` sampled at the previous clock edge.
- R4: With `sys_fault` high and `hold_clr_mode` = 0, `dac_word` keeps its previous value whatever the channel codes do.
- R5: With `sys_fault` high and `hold_clr_mode` = 1, `dac_word` becomes 0 one clock later. `hold_clr_mode` has no effect while `sys_fault` is low.
- R6: With `strobe_sel` = 2'b00, both strobe lines stay at 2'b11 (inactive) even when a start-up edge occurs.
- R7: Take the first clock edge at which `start_req` is sampled high after being sampled low. The selected strobe lines go low at the next clock edge and stay low for 31 clock cycles, which is 2**CNT_W - 1 cycles. They then return high.
- R8: Strobe line selection, with bit 0 of `load_strobe_n` as line 0: `strobe_sel` = 2'b01 drives only line 0 low (output 2'b10). 2'b10 drives only line 1 low (output 2'b01). 2'b11 drives both lines low (output 2'b00).
- R9: A rising edge on `start_req` while a pulse is running neither restarts nor extends that pulse. A `start_req` level held high after the pulse ends starts no new pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 100 MHz clock |
| rst | input | 1 | Synchronous reset, active high |
| ch0_code | input | 16 | Channel 0 conversion code |
| ch1_code | input | 16 | Channel 1 conversion code |
| data_en_in | input | 1 | Data-enable bit from the register file |
| hold_clr_mode | input | 1 | Fault action: 0 freezes the word, 1 clears it |
| sys_fault | input | 1 | System error notification |
| strobe_sel | input | 2 | Load-strobe line selection |
| start_req | input | 1 | Start-up request; its rising edge starts a strobe pulse |
| dac_word | output | 32 | Registered packed conversion word |
| dac_word_en | output | 1 | Registered data-enable |
| load_strobe_n | output | 2 | Registered active-low load strobe, one bit per line |

## Verification
A wrong pulse counter shows up at the strobe lines as a pulse that is too long or too short. It also shows up as a pulse that restarts when the request toggles. Both are visible at the 31st and 32nd cycle after the triggering edge, or on the cycle a retrigger would have begun. A wrong fault-action choice shows at `dac_word` on the first clock after `sys_fault` rises: the word is stale where it should be zero, or it follows new codes where it should be frozen. A stale edge-detector register shows up as a second pulse starting two cycles after the first one ends while the request is still held high.

// File: rtl/dac_upd_pkg.sv
package dac_upd_pkg;

    localparam int CODE_W  = 16;
    localparam int LINES   = 2;
    localparam int CNT_W   = 5;
    localparam int WORD_W  = 2 * CODE_W;
    localparam logic [CNT_W-1:0] PULSE_LEN = '1;

    typedef enum logic [1:0] {
        STB_OFF   = 2'b00,
        STB_LINE0 = 2'b01,
        STB_LINE1 = 2'b10,
        STB_BOTH  = 2'b11
    } strobe_sel_e;

    typedef enum logic [1:0] {
        FA_PASS  = 2'b00,
        FA_HOLD  = 2'b01,
        FA_CLEAR = 2'b10
    } fault_act_e;

    typedef struct packed {
        logic [CODE_W-1:0] hi;
        logic [CODE_W-1:0] lo;
    } dac_word_t;

    // Active-high mask of the lines that a selection drives
    function automatic logic [LINES-1:0] strobe_mask(strobe_sel_e sel);
        logic [LINES-1:0] m;
        case (sel)
            STB_LINE0: m = 2'b01;
            STB_LINE1: m = 2'b10;
            STB_BOTH:  m = 2'b11;
            default:   m = 2'b00;
        endcase
        return m;
    endfunction

    function automatic fault_act_e fault_action(logic fault, logic clr_mode);
        if (!fault)
            return FA_PASS;
        else if (clr_mode)
            return FA_CLEAR;
        else
            return FA_HOLD;
    endfunction

endpackage

// File: rtl/dac_word_reg.sv
module dac_word_reg
    import dac_upd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] lo_code,
    input  logic [CODE_W-1:0] hi_code,
    input  logic              en_in,
    input  fault_act_e        action,
    output dac_word_t         word_q,
    output logic              en_q
);

    dac_word_t word_d;

    always_comb begin
        word_d = word_q;
        case (action)
            FA_PASS: begin
                word_d.hi = hi_code;
                word_d.lo = lo_code;
            end
            FA_CLEAR: word_d = '0;
            default:  word_d = word_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
            en_q   <= 1'b0;
        end else begin
            word_q <= word_d;
            en_q   <= en_in;
        end
    end

endmodule

// File: rtl/start_edge_det.sv
module start_edge_det (
    input  logic clk,
    input  logic rst,
    input  logic level_in,
    output logic rise
);

    logic level_q;

    always_ff @(posedge clk) begin
        if (rst)
            level_q <= 1'b0;
        else
            level_q <= level_in;
    end

    assign rise = level_in & ~level_q;

endmodule

// File: rtl/strobe_timer.sv
module strobe_timer
    import dac_upd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             trigger,
    output logic [CNT_W-1:0] count,
    output logic             busy
);

    logic [CNT_W-1:0] count_q;

    always_ff @(posedge clk) begin
        if (rst)
            count_q <= '0;
        else if (count_q != '0)
            count_q <= count_q - 1'b1;
        else if (trigger)
            count_q <= PULSE_LEN;
    end

    assign count = count_q;
    assign busy  = (count_q != '0);

endmodule

// File: rtl/strobe_decode.sv
module strobe_decode
    import dac_upd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             busy,
    input  strobe_sel_e      sel,
    output logic [LINES-1:0] strobe_n
);

    logic [LINES-1:0] mask;

    assign mask = strobe_mask(sel);

    for (genvar i = 0; i < LINES; i++) begin : g_line
        always_ff @(posedge clk) begin
            if (rst)
                strobe_n[i] <= 1'b1;
            else
                strobe_n[i] <= ~(busy & mask[i]);
        end
    end

endmodule

// File: rtl/dac_update_ctrl.sv
module dac_update_ctrl
    import dac_upd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] ch0_code,
    input  logic [CODE_W-1:0] ch1_code,
    input  logic              data_en_in,
    input  logic              hold_clr_mode,
    input  logic              sys_fault,
    input  logic [1:0]        strobe_sel,
    input  logic              start_req,
    output logic [WORD_W-1:0] dac_word,
    output logic              dac_word_en,
    output logic [LINES-1:0]  load_strobe_n
);

    fault_act_e       action;
    dac_word_t        word_q;
    logic             start_rise;
    logic             tmr_busy;
    logic [CNT_W-1:0] tmr_count;

    assign action = fault_action(sys_fault, hold_clr_mode);

    dac_word_reg u_word (
        .clk     (clk),
        .rst     (rst),
        .lo_code (ch0_code),
        .hi_code (ch1_code),
        .en_in   (data_en_in),
        .action  (action),
        .word_q  (word_q),
        .en_q    (dac_word_en)
    );

    start_edge_det u_edge (
        .clk      (clk),
        .rst      (rst),
        .level_in (start_req),
        .rise     (start_rise)
    );

    strobe_timer u_timer (
        .clk     (clk),
        .rst     (rst),
        .trigger (start_rise),
        .count   (tmr_count),
        .busy    (tmr_busy)
    );

    strobe_decode u_dec (
        .clk      (clk),
        .rst      (rst),
        .busy     (tmr_busy),
        .sel      (strobe_sel_e'(strobe_sel)),
        .strobe_n (load_strobe_n)
    );

    assign dac_word = word_q;

endmodule

// File: rtl/dac_update_ctrl_chk.sv
module dac_update_ctrl_chk
    import dac_upd_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [CODE_W-1:0] ch0_code,
    input logic [CODE_W-1:0] ch1_code,
    input logic              data_en_in,
    input logic              hold_clr_mode,
    input logic              sys_fault,
    input logic [1:0]        strobe_sel,
    input logic [WORD_W-1:0] dac_word,
    input logic              dac_word_en,
    input logic [LINES-1:0]  load_strobe_n,
    input logic [CNT_W-1:0]  tmr_count
);

    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (dac_word == '0 && !dac_word_en && load_strobe_n == '1));

    a_r2_word_capture: assert property (@(posedge clk) disable iff (rst)
        !sys_fault |=> dac_word == $past({ch1_code, ch0_code}));

    a_r3_enable_copy: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> dac_word_en == $past(data_en_in));

    a_r4_fault_hold: assert property (@(posedge clk) disable iff (rst)
        (sys_fault && !hold_clr_mode) |=> $stable(dac_word));

    a_r5_fault_clear: assert property (@(posedge clk) disable iff (rst)
        (sys_fault && hold_clr_mode) |=> dac_word == '0);

    a_r6_off_idle: assert property (@(posedge clk) disable iff (rst)
        (strobe_sel == 2'b00) |=> load_strobe_n == 2'b11);

    a_r8_only_selected: assert property (@(posedge clk) disable iff (rst)
        (strobe_sel == 2'b01) |=> load_strobe_n[1]);

    a_r9_no_retrigger: assert property (@(posedge clk) disable iff (rst)
        (tmr_count != '0) |=> tmr_count == $past(tmr_count) - 1'b1);

endmodule

bind dac_update_ctrl dac_update_ctrl_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .ch0_code      (ch0_code),
    .ch1_code      (ch1_code),
    .data_en_in    (data_en_in),
    .hold_clr_mode (hold_clr_mode),
    .sys_fault     (sys_fault),
    .strobe_sel    (strobe_sel),
    .dac_word      (dac_word),
    .dac_word_en   (dac_word_en),
    .load_strobe_n (load_strobe_n),
    .tmr_count     (tmr_count)
);

// File: tb/dac_update_ctrl_test.sv
module dac_update_ctrl_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] ch0_code = '0;
    logic [15:0] ch1_code = '0;
    logic        data_en_in = 1'b0;
    logic        hold_clr_mode = 1'b0;
    logic        sys_fault = 1'b0;
    logic [1:0]  strobe_sel = 2'b00;
    logic        start_req = 1'b0;
    logic [31:0] dac_word;
    logic        dac_word_en;
    logic [1:0]  load_strobe_n;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    dac_update_ctrl uut (
        .clk           (clk),
        .rst           (rst),
        .ch0_code      (ch0_code),
        .ch1_code      (ch1_code),
        .data_en_in    (data_en_in),
        .hold_clr_mode (hold_clr_mode),
        .sys_fault     (sys_fault),
        .strobe_sel    (strobe_sel),
        .start_req     (start_req),
        .dac_word      (dac_word),
        .dac_word_en   (dac_word_en),
        .load_strobe_n (load_strobe_n)
    );

    // advance n rising edges, then settle away from the edge
    task automatic tick(int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic t_reset;
        rst = 1'b1;
        tick(2);
        check("R1 word", dac_word, 32'h0);
        check("R1 enable", {31'b0, dac_word_en}, 32'h0);
        check("R1 strobe", {30'b0, load_strobe_n}, 32'h3);
        rst = 1'b0;
    endtask

    task automatic t_capture;
        ch0_code = 16'h1234; ch1_code = 16'hABCD;
        tick(1);
        check("R2 pack", dac_word, 32'hABCD_1234);
        ch0_code = 16'hFFFF; ch1_code = 16'h0001;
        tick(1);
        check("R2 pack2", dac_word, 32'h0001_FFFF);
    endtask

    task automatic t_enable;
        data_en_in = 1'b1;
        tick(1);
        check("R3 en high", {31'b0, dac_word_en}, 32'h1);
        data_en_in = 1'b0;
        tick(1);
        check("R3 en low", {31'b0, dac_word_en}, 32'h0);
    endtask

    task automatic t_fault_hold;
        ch0_code = 16'h5555; ch1_code = 16'h6666;
        tick(1);
        hold_clr_mode = 1'b0; sys_fault = 1'b1;
        ch0_code = 16'h0BAD; ch1_code = 16'hBEEF;
        tick(1);
        check("R4 hold1", dac_word, 32'h6666_5555);
        tick(1);
        check("R4 hold2", dac_word, 32'h6666_5555);
        sys_fault = 1'b0;
        tick(1);
        check("R4 release", dac_word, 32'hBEEF_0BAD);
    endtask

    task automatic t_fault_clear;
        hold_clr_mode = 1'b1; sys_fault = 1'b1;
        tick(1);
        check("R5 clear", dac_word, 32'h0);
        sys_fault = 1'b0;
        ch0_code = 16'h0102; ch1_code = 16'h0304;
        tick(1);
        check("R5 mode no effect", dac_word, 32'h0304_0102);
        hold_clr_mode = 1'b0;
    endtask

    // start a pulse with the given selection and check its shape (R7)
    task automatic t_pulse(logic [1:0] sel, logic [1:0] exp_low, string req);
        strobe_sel = sel;
        start_req = 1'b1;
        tick(1);
        start_req = 1'b0;
        check({req, " R7 not yet"}, {30'b0, load_strobe_n}, 32'h3);
        tick(1);
        check({req, " R7 first"}, {30'b0, load_strobe_n}, {30'b0, exp_low});
        tick(30);
        check({req, " R7 last"}, {30'b0, load_strobe_n}, {30'b0, exp_low});
        tick(1);
        check({req, " R7 end"}, {30'b0, load_strobe_n}, 32'h3);
        tick(2);
    endtask

    task automatic t_sel_off;
        strobe_sel = 2'b00;
        start_req = 1'b1;
        tick(1);
        start_req = 1'b0;
        for (int i = 0; i < 34; i++) begin
            tick(1);
            if (load_strobe_n !== 2'b11)
                check("R6 off", {30'b0, load_strobe_n}, 32'h3);
        end
        check("R6 off final", {30'b0, load_strobe_n}, 32'h3);
    endtask

    task automatic t_retrigger;
        strobe_sel = 2'b01;
        start_req = 1'b1;
        tick(1);
        start_req = 1'b0;
        tick(9);
        start_req = 1'b1;
        tick(1);
        check("R9 mid", {30'b0, load_strobe_n}, 32'h2);
        tick(21);
        check("R9 still low", {30'b0, load_strobe_n}, 32'h2);
        tick(1);
        check("R9 no extend", {30'b0, load_strobe_n}, 32'h3);
        tick(5);
        check("R9 level no retrigger", {30'b0, load_strobe_n}, 32'h3);
        start_req = 1'b0;
        tick(1);
        t_pulse(2'b01, 2'b10, "R9 fresh edge");
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        #1;
        t_reset();
        t_capture();
        t_enable();
        t_fault_hold();
        t_fault_clear();
        t_sel_off();
        t_pulse(2'b01, 2'b10, "R8 line0");
        t_pulse(2'b10, 2'b01, "R8 line1");
        t_pulse(2'b11, 2'b00, "R8 both");
        t_retrigger();
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule